// File: doc/BRIEF.md
# Time-Multiplexed Unified Cache

This block is a small, fully associative cache that holds both instructions and data. An instruction-fetch port and a data port share it, and so does a single memory port that handles misses and writes. The tag and data array has one lookup port. The block divides time into two-clock processor cycles. The first clock of each pair belongs to the fetch port and the second clock belongs to the data port. The two requesters therefore never compete for the array, and the block needs no arbiter in front of it.

Three static control inputs shape how the array is used:

- **Fetch fill enable** lets a fetch miss install the returned word in the cache.
- **Load fill enable** lets a data read miss install the returned word in the cache.
- **Replacement enable** lets a fill evict a valid line once every entry is occupied.

With both fill enables high, the array acts as a unified cache. With only one fill enable high, it acts as a cache for that access type only. Stores are written through to memory and never allocate a line.

Each requester holds its request until it receives a one-clock acknowledge. A miss stalls only the port that missed. The memory port carries at most one transaction at a time.

Top module: `ucache_tdm`

## Requirements
- R1: After reset, both acknowledges and the memory request are low, and no entry is valid, so the first access to any address goes to memory.
- R2: The slot phase alternates every clock and begins with the fetch slot after reset. A fetch is looked up on the fetch-slot edge and a data access on the data-slot edge. A hit raises its port's acknowledge for exactly one clock, in the clock that follows its slot. A hit therefore completes within two clocks of the request, whatever the other port is doing.
- R3: With the fetch fill enable high, a fetch miss installs its word, and a repeat fetch of that address hits. With the enable low, a fetch miss is still answered with the memory word, but nothing is installed.
- R4: With the load fill enable high, a data read miss installs its word. With it low, a data read miss is answered without installing anything.
- R5: A store to an address that is not cached is written to memory and installs nothing, so a following read of that address misses.
- R6: Every store issues a memory write with its address and data, and it is acknowledged only after the memory acknowledges. A store that hits also updates the cached word, so a later fetch or load of that address hits and returns the new value.
- R7: With replacement disabled and all entries valid, a miss is answered from memory and no line is evicted. Every previously cached address still hits.
- R8: A fill uses the lowest-numbered invalid entry. When no entry is invalid and replacement is enabled, the victim is chosen by a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, only when it is used for an eviction.
- R9: Only one memory transaction is outstanding at a time. The memory request, address, write flag and write data stay stable until the memory acknowledge, and the request is low in the clock after that acknowledge.
- R10: A read miss returns the memory word for its address, and a read hit returns the latest value written to that address.
- R11: While one port waits for memory, the other port continues to be served in its own slot, and its hits complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ifill_en | input | 1 | Fetch misses may install lines |
| cfg_dfill_en | input | 1 | Data read misses may install lines |
| cfg_repl_en | input | 1 | Fills may evict a valid line when the cache is full |
| if_req | input | 1 | Fetch request, held until if_ack |
| if_addr | input | ADDR_W | Fetch word address |
| if_ack | output | 1 | One-clock fetch completion |
| if_rdata | output | DATA_W | Fetch data, valid with if_ack |
| d_req | input | 1 | Data request, held until d_ack |
| d_we | input | 1 | 1 = store, 0 = load |
| d_addr | input | ADDR_W | Data word address |
| d_wdata | input | DATA_W | Store data |
| d_ack | output | 1 | One-clock data completion |
| d_rdata | output | DATA_W | Load data, valid with d_ack |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-clock memory completion |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The assertions check the following on every clock:

- the memory handshake rules (stability while waiting, and release after the acknowledge);
- that hit acknowledges arrive only in the clock after their own slot;
- that acknowledges last a single clock;
- that a store is acknowledged only after a memory write completes.

Whether an access hits or misses, which entry a fill takes, and whether fills and evictions are suppressed by the control bits can only be shown by the bench's scenarios. The bench predicts each access with an arithmetic model of the entries and the victim pointer, then compares that prediction with the memory traffic and the returned data.

// File: rtl/ucache_pkg.sv
package ucache_pkg;
   typedef enum logic {
      OWN_FETCH = 1'b0,
      OWN_DATA  = 1'b1
   } cache_owner_e;
endpackage

// File: rtl/ucache_tag_array.sv
module ucache_tag_array #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  lk_addr,
   output logic               lk_hit,
   output logic [IDX_W-1:0]   lk_idx,
   output logic [DATA_W-1:0]  lk_data,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ADDR_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0]  wr_data
);
   logic [ENTRIES-1:0] match;
   logic [DATA_W-1:0]  ent_data [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              v_q;
      logic [ADDR_W-1:0] t_q;
      logic [DATA_W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            v_q <= 1'b1;
            t_q <= wr_tag;
            d_q <= wr_data;
         end
      end

      assign valid_vec[e] = v_q;
      assign match[e]     = v_q && (t_q == lk_addr);
      assign ent_data[e]  = d_q;
   end

   always_comb begin
      lk_hit  = 1'b0;
      lk_idx  = '0;
      lk_data = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) begin
            lk_hit  = 1'b1;
            lk_idx  = IDX_W'(e);
            lk_data = ent_data[e];
         end
      end
   end
endmodule

// File: rtl/ucache_victim.sv
module ucache_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               repl_en,
   input  logic               take,
   output logic [IDX_W-1:0]   vic_idx,
   output logic               vic_ok
);
   logic             free_found;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_next;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(e);
         end
      end
   end

   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_wrap_pow2
      assign rr_next = rr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_next = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (take && !free_found)
         rr_q <= rr_next;
   end

   assign vic_ok  = free_found || repl_en;
   assign vic_idx = free_found ? free_idx : rr_q;
endmodule

// File: rtl/ucache_tdm.sv
module ucache_tdm #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ifill_en,
   input  logic              cfg_dfill_en,
   input  logic              cfg_repl_en,
   input  logic              if_req,
   input  logic [ADDR_W-1:0] if_addr,
   output logic              if_ack,
   output logic [DATA_W-1:0] if_rdata,
   input  logic              d_req,
   input  logic              d_we,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [DATA_W-1:0] d_wdata,
   output logic              d_ack,
   output logic [DATA_W-1:0] d_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   import ucache_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ucache_tdm: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ucache_tdm: widths must be positive");
   end

   // slot_q = 0: fetch clock, slot_q = 1: data clock
   logic              slot_q;
   logic              mem_req_q, mem_we_q;
   logic [ADDR_W-1:0] mem_addr_q;
   logic [DATA_W-1:0] mem_wdata_q;
   cache_owner_e      own_q;
   logic              if_ack_q, d_ack_q;
   logic [DATA_W-1:0] if_rdata_q, d_rdata_q;

   logic               lk_hit;
   logic [IDX_W-1:0]   lk_idx;
   logic [DATA_W-1:0]  lk_data;
   logic [ENTRIES-1:0] valid_vec;
   logic [ADDR_W-1:0]  lk_addr;
   logic [IDX_W-1:0]   vic_idx;
   logic               vic_ok;

   logic f_turn, d_turn, f_hit_go, f_miss_go, d_rd_hit, d_rd_miss, d_wr_go;
   logic mem_done, fill_bit, do_fill;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic [ADDR_W-1:0]  wr_tag;
   logic [DATA_W-1:0]  wr_data;

   assign lk_addr = slot_q ? d_addr : if_addr;

   always_comb begin
      f_turn    = !slot_q && if_req && !if_ack_q && !(mem_req_q && own_q == OWN_FETCH);
      d_turn    =  slot_q && d_req  && !d_ack_q  && !(mem_req_q && own_q == OWN_DATA);
      f_hit_go  = f_turn && lk_hit;
      f_miss_go = f_turn && !lk_hit && !mem_req_q;
      d_rd_hit  = d_turn && !d_we && lk_hit;
      d_rd_miss = d_turn && !d_we && !lk_hit && !mem_req_q;
      d_wr_go   = d_turn && d_we && !mem_req_q;
      mem_done  = mem_req_q && mem_ack;
      fill_bit  = (own_q == OWN_FETCH) ? cfg_ifill_en : cfg_dfill_en;
      do_fill   = mem_done && !mem_we_q && fill_bit && vic_ok;
      wr_en     = do_fill || (d_wr_go && lk_hit);
      wr_idx    = do_fill ? vic_idx    : lk_idx;
      wr_tag    = do_fill ? mem_addr_q : d_addr;
      wr_data   = do_fill ? mem_rdata  : d_wdata;
   end

   ucache_tag_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_data(lk_data),
      .valid_vec(valid_vec),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
   );

   ucache_victim #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk(clk), .rst_n(rst_n),
      .valid_vec(valid_vec), .repl_en(cfg_repl_en), .take(do_fill),
      .vic_idx(vic_idx), .vic_ok(vic_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q      <= 1'b0;
         mem_req_q   <= 1'b0;
         mem_we_q    <= 1'b0;
         mem_addr_q  <= '0;
         mem_wdata_q <= '0;
         own_q       <= OWN_FETCH;
         if_ack_q    <= 1'b0;
         d_ack_q     <= 1'b0;
         if_rdata_q  <= '0;
         d_rdata_q   <= '0;
      end else begin
         slot_q <= ~slot_q;

         if (mem_done) begin
            mem_req_q <= 1'b0;
         end else if (f_miss_go) begin
            mem_req_q  <= 1'b1;
            mem_we_q   <= 1'b0;
            mem_addr_q <= if_addr;
            own_q      <= OWN_FETCH;
         end else if (d_rd_miss || d_wr_go) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= d_we;
            mem_addr_q  <= d_addr;
            mem_wdata_q <= d_wdata;
            own_q       <= OWN_DATA;
         end

         if_ack_q <= f_hit_go || (mem_done && own_q == OWN_FETCH);
         if (f_hit_go)
            if_rdata_q <= lk_data;
         else if (mem_done && own_q == OWN_FETCH)
            if_rdata_q <= mem_rdata;

         d_ack_q <= d_rd_hit || (mem_done && own_q == OWN_DATA);
         if (d_rd_hit)
            d_rdata_q <= lk_data;
         else if (mem_done && own_q == OWN_DATA && !mem_we_q)
            d_rdata_q <= mem_rdata;
      end
   end

   assign if_ack    = if_ack_q;
   assign if_rdata  = if_rdata_q;
   assign d_ack     = d_ack_q;
   assign d_rdata   = d_rdata_q;
   assign mem_req   = mem_req_q;
   assign mem_we    = mem_we_q;
   assign mem_addr  = mem_addr_q;
   assign mem_wdata = mem_wdata_q;
endmodule

// File: rtl/ucache_tdm_chk.sv
module ucache_tdm_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slot,
   input logic              if_ack,
   input logic              d_ack,
   input logic              d_we,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r9_mem_release: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !mem_req);

   a_r2_fetch_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(if_ack) && !$past(mem_ack) |-> slot);

   a_r2_data_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(d_ack) && !$past(mem_ack) |-> !slot);

   a_r2_fetch_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      if_ack |=> !if_ack);

   a_r2_data_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      d_ack |=> !d_ack);

   a_r6_store_after_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
      d_ack && d_we |-> $past(mem_ack && mem_we && mem_req));
endmodule

bind ucache_tdm ucache_tdm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slot(slot_q),
   .if_ack(if_ack), .d_ack(d_ack), .d_we(d_we),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/ucache_tdm_bench.sv
module ucache_tdm_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic cfg_ifill_en = 1'b1, cfg_dfill_en = 1'b1, cfg_repl_en = 1'b1;
   logic if_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
   logic [7:0]  if_addr = '0, d_addr = '0;
   logic [15:0] d_wdata = '0;
   logic        if_ack, d_ack, mem_req, mem_we;
   logic [15:0] if_rdata, d_rdata, mem_wdata;
   logic [7:0]  mem_addr;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;

   ucache_tdm u_ucache_tdm (
      .clk(clk), .rst_n(rst_n),
      .cfg_ifill_en(cfg_ifill_en), .cfg_dfill_en(cfg_dfill_en), .cfg_repl_en(cfg_repl_en),
      .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_rdata(if_rdata),
      .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
      .d_ack(d_ack), .d_rdata(d_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_chk = 0, n_err = 0;
   int lat = 4, cnt = 0;
   int n_rd = 0, n_wr = 0;
   logic [7:0]  last_wa;
   logic [15:0] last_wd;
   logic [15:0] mem_arr [256];
   logic [15:0] exp_mem [256];
   bit          m_valid [16];
   logic [7:0]  m_tag [16];
   int          m_rr = 0;
   bit          f_done;

   // memory model
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         cnt     <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         cnt     <= 0;
      end else if (mem_req) begin
         if (cnt >= lat - 1) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_arr[mem_addr];
            if (mem_we) begin
               mem_arr[mem_addr] <= mem_wdata;
               n_wr    <= n_wr + 1;
               last_wa <= mem_addr;
               last_wd <= mem_wdata;
            end else begin
               n_rd <= n_rd + 1;
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input int kind, input logic [7:0] a, input logic [15:0] wd,
                        output logic [15:0] got, output int cyc);
      @(negedge clk);
      if (kind == 0) begin
         if_addr = a; if_req = 1'b1;
      end else begin
         d_addr = a; d_we = (kind == 2); d_wdata = wd; d_req = 1'b1;
      end
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!(kind == 0 ? if_ack : d_ack) && cyc < 2000);
      got = (kind == 0) ? if_rdata : d_rdata;
      if (kind == 0) if_req = 1'b0; else d_req = 1'b0;
      if (cyc >= 2000) check(1'b0, "R9", "access timed out", 32'(cyc), 32'd0);
   endtask

   // kind: 0 fetch, 1 load, 2 store; predicts outcome from the requirements
   task automatic do_acc(input int kind, input logic [7:0] a, input logic [15:0] wd,
                         input string rq);
      int rd0 = n_rd, wr0 = n_wr, cyc, free_e;
      logic [15:0] got;
      bit hit = 1'b0, fill_ok;
      for (int e = 0; e < 16; e++) if (m_valid[e] && m_tag[e] == a) hit = 1'b1;
      drive(kind, a, wd, got, cyc);
      if (kind == 2) begin
         check(n_wr == wr0 + 1 && n_rd == rd0, rq, "store memory write count", 32'(n_wr - wr0), 32'd1);
         check(last_wa == a && last_wd == wd, rq, "store address/data at memory",
               {last_wa, last_wd}, {a, wd});
         exp_mem[a] = wd;
      end else begin
         check(n_rd == rd0 + (hit ? 0 : 1), rq, hit ? "hit made memory read" : "miss memory read count",
               32'(n_rd - rd0), hit ? 32'd0 : 32'd1);
         if (hit) check(cyc <= 2, "R2", "hit latency", 32'(cyc), 32'd2);
         check(got == exp_mem[a], "R10", "read data", 32'(got), 32'(exp_mem[a]));
         fill_ok = (kind == 0) ? cfg_ifill_en : cfg_dfill_en;
         if (!hit && fill_ok) begin
            free_e = -1;
            for (int e = 15; e >= 0; e--) if (!m_valid[e]) free_e = e;
            if (free_e >= 0) begin
               m_valid[free_e] = 1'b1; m_tag[free_e] = a;
            end else if (cfg_repl_en) begin
               m_tag[m_rr] = a; m_rr = (m_rr + 1) % 16;
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] got;
      int cyc, cyc2;
      logic [15:0] got2;
      for (int a = 0; a < 256; a++) begin
         mem_arr[a] = 16'(a * 16'h0101) ^ 16'h5A5A;
         exp_mem[a] = mem_arr[a];
      end
      for (int e = 0; e < 16; e++) begin m_valid[e] = 1'b0; m_tag[e] = '0; end
      repeat (3) @(negedge clk);
      check(!if_ack && !d_ack && !mem_req, "R1", "outputs in reset",
            {29'd0, if_ack, d_ack, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!if_ack && !d_ack && !mem_req, "R1", "outputs after reset",
            {29'd0, if_ack, d_ack, mem_req}, 32'd0);

      // fills enabled
      do_acc(0, 8'h10, 0, "R1");
      do_acc(0, 8'h10, 0, "R3");
      do_acc(1, 8'h20, 0, "R4");
      do_acc(1, 8'h20, 0, "R4");

      // both ports hitting together
      fork
         begin drive(0, 8'h10, 0, got, cyc); end
         begin drive(1, 8'h20, 0, got2, cyc2); end
      join
      check(cyc <= 2 && cyc2 <= 2, "R2", "concurrent hit latencies", {cyc[15:0], cyc2[15:0]}, 32'h0002_0002);
      check(got == exp_mem[8'h10] && got2 == exp_mem[8'h20], "R10", "concurrent hit data",
            {got, got2}, {exp_mem[8'h10], exp_mem[8'h20]});

      // a fetch miss must not block data hits
      lat = 20; f_done = 1'b0;
      fork
         begin do_acc(0, 8'hA0, 0, "R11"); f_done = 1'b1; end
         begin
            repeat (4) @(negedge clk);
            drive(1, 8'h20, 0, got, cyc);
            check(!f_done, "R11", "data hit finished before fetch miss", 32'(f_done), 32'd0);
            check(cyc <= 2 && got == exp_mem[8'h20], "R11", "data hit during fetch miss",
                  {cyc[15:0], got}, {16'd2, exp_mem[8'h20]});
         end
      join
      lat = 4;

      // fill enables cleared
      cfg_ifill_en = 1'b0;
      do_acc(0, 8'h30, 0, "R3");
      do_acc(0, 8'h30, 0, "R3");
      do_acc(0, 8'h10, 0, "R3");
      cfg_ifill_en = 1'b1;
      cfg_dfill_en = 1'b0;
      do_acc(1, 8'h40, 0, "R4");
      do_acc(1, 8'h40, 0, "R4");
      cfg_dfill_en = 1'b1;

      // write-no-allocate and write-through
      do_acc(2, 8'h50, 16'h1234, "R5");
      do_acc(1, 8'h50, 0, "R5");
      do_acc(2, 8'h20, 16'hBEEF, "R6");
      do_acc(1, 8'h20, 0, "R6");
      do_acc(0, 8'h20, 0, "R6");

      // fill the array with replacement off
      cfg_repl_en = 1'b0;
      for (int k = 0; k < 16; k++) do_acc(1, 8'(8'h80 + k), 0, "R7");
      do_acc(1, 8'h90, 0, "R7");
      do_acc(1, 8'h90, 0, "R7");
      for (int e = 0; e < 16; e++) do_acc(1, m_tag[e], 0, "R7");

      // round-robin eviction
      cfg_repl_en = 1'b1;
      do_acc(1, 8'h91, 0, "R8");
      do_acc(1, 8'h10, 0, "R8");
      do_acc(0, 8'h20, 0, "R8");
      do_acc(1, 8'hA0, 0, "R8");
      do_acc(0, 8'h91, 0, "R8");
      for (int e = 0; e < 16; e++) do_acc(0, m_tag[e], 0, "R8");

      // sweep over access kinds, addresses and control settings
      for (int i = 0; i < 240; i++) begin
         int ph = i / 48;
         int kind = (i * 5) % 3;
         cfg_ifill_en = (ph != 2);
         cfg_dfill_en = (ph != 3);
         cfg_repl_en  = (ph != 1);
         do_acc(kind, 8'(8'h40 + (i * 11) % 29), 16'(i * 16'h0123 + 7),
                kind == 0 ? "R3" : (kind == 1 ? "R4" : "R6"));
      end

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule